// File: doc/BRIEF.md
# Quad Down-Counting PWM Timer with Complementary Dead-Time Pairs

This block holds four independent pulse-width modulation channels. Each channel has a 16-bit counter that starts at a programmed period value and counts down by one per clock. On every pass through zero the channel raises a sticky interrupt flag, so interrupts stay locked to the PWM period. In continuous mode the counter reloads its period and keeps running. In one-shot mode it stops at zero after one pass. The channel level goes high at each load or reload. It goes low once the counter has passed the programmed compare value.

Channels 0/1 and 2/3 can each be joined into a complementary pair. The odd pin then carries the inverse of the even channel's level. Every rising edge on either pin is held back by a programmable dead-time count, so the two pins are never high together. The period, compare and dead-time values are presented as held register values at the block's inputs. The period and compare values are copied into working copies only when a channel loads or reloads. A host writes the register values and enables and reads the pins and flags. Every pin leaves the block through one output register.

Top module: `pwm_quad`

## Requirements
- R1: After synchronous reset, all of `pwm_o` and all of `irq_o` are 0.
- R2: Enabling channel i (`chan_en[i]`=1) loads period P into its counter. The counter then steps down once per clock through P, P-1, ... 0. In continuous mode this gives a cycle of P+1 clocks. With the enable first seen at edge k, `irq_o[i]` is 0 after edge k+P and 1 after edge k+P+1.
- R3: Pin timing in continuous mode, with enable first seen at edge k, unpaired, compare C ≤ P:
  - The channel level after edge k+m is low when (m mod (P+1)) ≥ P-C+1, and high otherwise.
  - `pwm_o[i]` is 0 after edge k. After edge k+j (j ≥ 1) it equals the level after edge k+j-1, so each period has C low clocks.
- R4: A compare value of 0, or any value greater than the period, gives a level that stays high for as long as the channel runs.
- R5: In one-shot mode (`oneshot[i]`=1) the counter stops after reaching zero and sets the flag exactly once. The pin then stays 0 until the enable is removed and applied again.
- R6: `irq_o[i]` stays set until a cycle with `irq_clr[i]`=1 and no new zero event. A zero event in the same cycle as a clear leaves the flag set.
- R7: Pair mode (`pair_en[p]`=1) joins channels 2p and 2p+1, with D = `dead_i[p*DT_W +: DT_W]`.
  - The even pin's source is the even channel's level.
  - The odd pin's source is the inverse of that level while the even channel runs, and 0 otherwise.
  - A pin is 1 after an edge only if its source was 1 at that edge and at each of the D edges before it. Each rising edge is therefore delayed by D clocks, and both pins are never 1 together.
- R8: A period or compare value changed while a channel runs does not affect the cycle in progress. It takes effect at the next reload.
- R9: Dropping `chan_en[i]` stops the counter and forces the level low at the next edge. The pin is 0 one clock later, and no further zero event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | NCH | Per-channel run enable |
| oneshot | input | NCH | Per-channel one-shot select (0 = continuous) |
| pair_en | input | NCH/2 | Complementary pair enable, bit p joins channels 2p and 2p+1 |
| period_i | input | NCH*CNT_W | Period value per channel, channel i at [i*CNT_W +: CNT_W] |
| cmp_i | input | NCH*CNT_W | Compare value per channel, same packing |
| dead_i | input | NCH/2*DT_W | Dead-time count per pair |
| irq_clr | input | NCH | Write-one-to-clear strobe per flag |
| pwm_o | output | NCH | Registered PWM pins |
| irq_o | output | NCH | Sticky zero-reached interrupt flags |

## Verification
Continuous runs are tried with several period/compare mixes, including compare equal to the period. Each run tells an off-by-one in the reload phase apart from one in the match phase. Compare values of zero and beyond the period separate a missing "never match" path from a wrong low window. A pair run with a dead count of three is checked clock by clock against the delayed complementary model, which exposes both a wrong inversion and a wrong delay length. Mid-run period changes, one-shot stops, disable and clearing while a zero event lands tell apart reload-time copying, the stop, the abort and set-over-clear priority.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int unsigned PWM_CNT_W = 16;
  localparam int unsigned PWM_DT_W  = 8;

  typedef struct packed {
    logic [PWM_CNT_W-1:0] per;
    logic [PWM_CNT_W-1:0] cmp;
  } pwm_shadow_t;
endpackage

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_quad_pkg::*;
#(
  parameter int unsigned CNT_W = PWM_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             oneshot,
  input  logic [CNT_W-1:0] per_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic             out_lvl,
  output logic             running,
  output logic             zero_evt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_per;
  logic [CNT_W-1:0] cur_cmp;
  logic             fired;
  logic             at_zero;

  assign at_zero  = (cnt == '0);
  assign zero_evt = running && en && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cur_per <= '0;
      cur_cmp <= '0;
      running <= 1'b0;
      fired   <= 1'b0;
      out_lvl <= 1'b0;
    end else if (!en) begin
      cnt     <= '0;
      running <= 1'b0;
      fired   <= 1'b0;
      out_lvl <= 1'b0;
    end else if (!running) begin
      if (!fired) begin
        cnt     <= per_in;
        cur_per <= per_in;
        cur_cmp <= cmp_in;
        running <= 1'b1;
        out_lvl <= 1'b1;
      end else begin
        out_lvl <= 1'b0;
      end
    end else if (at_zero) begin
      if (oneshot) begin
        running <= 1'b0;
        fired   <= 1'b1;
        out_lvl <= 1'b0;
      end else begin
        cnt     <= per_in;
        cur_per <= per_in;
        cur_cmp <= cmp_in;
        out_lvl <= 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == cur_cmp) out_lvl <= 1'b0;
    end
  end

  // R2: a running counter never exceeds its working period
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt <= cur_per));

  // R3: continuous zero reloads from the presented period
  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (running && en && at_zero && !oneshot) |=> (cnt == $past(per_in)));

  // R3: passing the compare value drives the level low
  p_match_low_r3: assert property (@(posedge clk) disable iff (rst)
    (running && en && !at_zero && (cnt == cur_cmp)) |=> !out_lvl);

  // R5: one-shot stops at zero
  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (running && en && at_zero && oneshot) |=> !running);

  // R9: removing the enable halts the channel
  p_disable_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!running && !out_lvl));
endmodule

// File: rtl/pwm_flag.sv
module pwm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R6: set wins over clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    set |=> q);

  // R6: flag is sticky without a clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
endmodule

// File: rtl/pwm_dz_leg.sv
module pwm_dz_leg
  import pwm_quad_pkg::*;
#(
  parameter int unsigned DT_W = PWM_DT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src,
  input  logic [DT_W-1:0] dt,
  output logic            o
);
  logic [DT_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      o    <= 1'b0;
    end else if (!src) begin
      hold <= '0;
      o    <= 1'b0;
    end else if (hold >= dt) begin
      o    <= 1'b1;
    end else begin
      hold <= hold + 1'b1;
    end
  end

  // R7: a pin is only high when its source was high at the last edge
  p_src_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !src |=> !o);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = PWM_CNT_W,
  parameter int unsigned DT_W  = PWM_DT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        chan_en,
  input  logic [NCH-1:0]        oneshot,
  input  logic [NCH/2-1:0]      pair_en,
  input  logic [NCH*CNT_W-1:0]  period_i,
  input  logic [NCH*CNT_W-1:0]  cmp_i,
  input  logic [NCH/2*DT_W-1:0] dead_i,
  input  logic [NCH-1:0]        irq_clr,
  output logic [NCH-1:0]        pwm_o,
  output logic [NCH-1:0]        irq_o
);
  localparam int unsigned NPAIR = NCH / 2;

  logic [NCH-1:0] lvl;
  logic [NCH-1:0] run;
  logic [NCH-1:0] zev;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_shadow_t cfg;
    assign cfg.per = period_i[i*CNT_W +: CNT_W];
    assign cfg.cmp = cmp_i[i*CNT_W +: CNT_W];

    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .en       (chan_en[i]),
      .oneshot  (oneshot[i]),
      .per_in   (cfg.per),
      .cmp_in   (cfg.cmp),
      .out_lvl  (lvl[i]),
      .running  (run[i]),
      .zero_evt (zev[i])
    );

    pwm_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (zev[i]),
      .clr (irq_clr[i]),
      .q   (irq_o[i])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic            src_e;
    logic            src_o;
    logic [DT_W-1:0] dt_eff;

    assign src_e  = lvl[2*p];
    assign src_o  = pair_en[p] ? (run[2*p] & ~lvl[2*p]) : lvl[2*p+1];
    assign dt_eff = pair_en[p] ? dead_i[p*DT_W +: DT_W] : '0;

    pwm_dz_leg #(.DT_W(DT_W)) u_leg_e (
      .clk (clk), .rst (rst), .src (src_e), .dt (dt_eff), .o (pwm_o[2*p])
    );
    pwm_dz_leg #(.DT_W(DT_W)) u_leg_o (
      .clk (clk), .rst (rst), .src (src_o), .dt (dt_eff), .o (pwm_o[2*p+1])
    );

    // R7: paired pins are never high together
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
      pair_en[p] |=> !(pwm_o[2*p] && pwm_o[2*p+1]));
  end

  // R1: reset clears pins and flags
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pwm_o == '0 && irq_o == '0));
endmodule

// File: tb/pwm_quad_test.sv
module pwm_quad_test;
  localparam int CLK_NS = 10;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]      chan_en = '0;
  logic [NCH-1:0]      oneshot = '0;
  logic [NCH/2-1:0]    pair_en = '0;
  logic [NCH*CW-1:0]   period_i = '0;
  logic [NCH*CW-1:0]   cmp_i = '0;
  logic [NCH/2*DW-1:0] dead_i = '0;
  logic [NCH-1:0]      irq_clr = '0;
  logic [NCH-1:0]      pwm_o;
  logic [NCH-1:0]      irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwm_quad uut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .oneshot(oneshot),
    .pair_en(pair_en), .period_i(period_i), .cmp_i(cmp_i), .dead_i(dead_i),
    .irq_clr(irq_clr), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit lvl(int m, int p, int c);
    int ph;
    if (m < 0) return 1'b0;
    ph = m % (p + 1);
    return !(c <= p && ph >= p - c + 1);
  endfunction

  function automatic bit dz(int j, int d, int p, int c, bit odd);
    bit r = 1'b1;
    for (int i = 0; i <= d; i++) begin
      int m = j - 1 - i;
      bit v;
      if (m < 0) v = 1'b0;
      else       v = odd ? !lvl(m, p, c) : lvl(m, p, c);
      r &= v;
    end
    return r;
  endfunction

  task automatic idle();
    chan_en = '0;
    oneshot = '0;
    pair_en = '0;
    repeat (12) step();
    irq_clr = '1;
    step();
    irq_clr = '0;
    step();
  endtask

  task automatic set_ch(int ch, int p, int c);
    period_i[ch*CW +: CW] = p[CW-1:0];
    cmp_i[ch*CW +: CW]    = c[CW-1:0];
  endtask

  task automatic t_reset();
    chk("R1 pwm_o", int'(pwm_o), 0);
    chk("R1 irq_o", int'(irq_o), 0);
  endtask

  // R2 R3 R4: continuous waveform and first interrupt timing
  task automatic t_cont(int ch, int p, int c, int n, string req);
    set_ch(ch, p, c);
    chan_en[ch] = 1'b1;
    for (int j = 0; j < n; j++) begin
      step();
      chk(req, int'(pwm_o[ch]), (j == 0) ? 0 : int'(lvl(j - 1, p, c)));
      if (j == p)     chk("R2 irq before zero", int'(irq_o[ch]), 0);
      if (j == p + 1) chk("R2 irq at zero", int'(irq_o[ch]), 1);
    end
    idle();
  endtask

  task automatic t_pair(int d, int p, int c);
    set_ch(0, p, c);
    dead_i[DW-1:0] = d[DW-1:0];
    pair_en[0] = 1'b1;
    step();
    chan_en[0] = 1'b1;
    for (int j = 0; j < 3 * (p + 1); j++) begin
      step();
      chk("R7 even pin", int'(pwm_o[0]), int'(dz(j, d, p, c, 1'b0)));
      chk("R7 odd pin", int'(pwm_o[1]), int'(dz(j, d, p, c, 1'b1)));
      chk("R7 overlap", int'(pwm_o[0] & pwm_o[1]), 0);
    end
    idle();
  endtask

  task automatic t_oneshot();
    set_ch(2, 4, 2);
    oneshot[2] = 1'b1;
    chan_en[2] = 1'b1;
    for (int j = 0; j < 6; j++) step();
    chk("R5 irq set once", int'(irq_o[2]), 1);
    irq_clr[2] = 1'b1;
    step();
    irq_clr[2] = 1'b0;
    for (int j = 0; j < 10; j++) step();
    chk("R5 no second irq", int'(irq_o[2]), 0);
    chk("R5 pin low after stop", int'(pwm_o[2]), 0);
    idle();
  endtask

  task automatic t_midwrite();
    set_ch(3, 5, 0);
    chan_en[3] = 1'b1;
    for (int j = 0; j < 7; j++) begin
      step();
      if (j == 2) period_i[3*CW +: CW] = 16'd9;
    end
    chk("R8 old period holds", int'(irq_o[3]), 1);
    irq_clr[3] = 1'b1;
    step();
    irq_clr[3] = 1'b0;
    for (int j = 8; j < 16; j++) step();
    chk("R8 new period not yet", int'(irq_o[3]), 0);
    step();
    chk("R8 new period zero", int'(irq_o[3]), 1);
    idle();
  endtask

  task automatic t_setwins();
    set_ch(1, 3, 0);
    irq_clr[1] = 1'b1;
    chan_en[1] = 1'b1;
    for (int j = 0; j < 5; j++) step();
    chk("R6 set beats clear", int'(irq_o[1]), 1);
    step();
    chk("R6 clear takes effect", int'(irq_o[1]), 0);
    irq_clr[1] = 1'b0;
    chan_en[1] = 1'b0;
    step();
    chk("R6 stays clear", int'(irq_o[1]), 0);
    idle();
  endtask

  task automatic t_disable();
    set_ch(0, 9, 0);
    chan_en[0] = 1'b1;
    for (int j = 0; j < 4; j++) step();
    chan_en[0] = 1'b0;
    step();
    chk("R9 pin still high", int'(pwm_o[0]), 1);
    step();
    chk("R9 pin low", int'(pwm_o[0]), 0);
    repeat (15) step();
    chk("R9 no zero event", int'(irq_o[0]), 0);
    idle();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_cont(0, 5, 2, 20, "R3 level P5 C2");
    t_cont(2, 7, 7, 20, "R3 level C equals P");
    t_cont(3, 3, 1, 12, "R3 level P3 C1");
    t_cont(1, 4, 0, 12, "R4 compare zero");
    t_cont(0, 4, 9, 12, "R4 compare above period");
    t_pair(3, 7, 3);
    t_pair(0, 5, 2);
    t_oneshot();
    t_midwrite();
    t_setwins();
    t_disable();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule